// File: doc/BRIEF.md
# Transceiver Operating Mode Controller

This block holds the operating mode of a single-wire bus transceiver. It decides when the external voltage regulator is switched on, when the transmit and receive paths are live, and when the bus termination is connected. It has four modes: off (no valid supply), standby (regulator on, waiting for the host), run (full communication) and sleep (low power, weak pull-up only). Supply-valid detection with hysteresis and the wake-up pulse filters sit outside the block. It receives their results as single-bit inputs that are already synchronous to `clk`.

The host moves the block between modes with a single enable pin. The pin is qualified separately in each direction: it must be seen high on `NORM_DELAY` consecutive clock edges to enter run, and low on `SLEEP_DELAY` consecutive edges to enter sleep. A qualified bus or local wake pulse in sleep returns the block to standby. It then pulls the receive output low to interrupt the host, and for a local wake it also asserts a strong pull-down request on the transmit pin to mark the wake source. Both flags drop at the first clock edge that samples enable high. All outputs are registered and change on the same edge as the mode.

Top module: `lin_mode_controller`

## Requirements
- R1: While reset is asserted the block is in the off mode, with `inhibit`, `commEnable`, `termEnable` and `txdStrongPull` at 0 and `rxdOut` at 1.
- R2: In off mode, the first edge that samples `supplyOk` high enters standby. At that same edge `inhibit` and `termEnable` become 1 and `commEnable` stays 0, so the regulator is enabled one clock after supply becomes valid.
- R3: An edge that samples `supplyOk` low enters off mode from any mode and clears both wake flags. This takes priority over every other input.
- R4: In standby, the edge that completes `NORM_DELAY` consecutive high samples of `enPin` enters run. In run, `inhibit`, `termEnable` and `commEnable` are 1 and `rxdOut` is `busRx` as sampled on each edge.
- R5: In run, the edge that completes `SLEEP_DELAY` consecutive low samples of `enPin` enters sleep. In sleep, `inhibit`, `commEnable` and `termEnable` are 0 and `rxdOut` is 1.
- R6: An enable level held for fewer consecutive samples than its delay changes no mode, and any opposite sample restarts the count.
- R7: In sleep, an edge that samples `busWake` or `localWake` high (and enable not qualified high) enters standby, sets the wake-request flag and drives `rxdOut` to 0 while standby lasts. Standby has `inhibit` and `termEnable` at 1.
- R8: The wake-source flag is set when the waking edge samples `localWake` high, even together with `busWake`. `txdStrongPull` is 1 in standby while both flags are set, and is 0 after a wake by `busWake` alone.
- R9: Any edge that samples `enPin` high clears both wake flags at that edge (`rxdOut` returns to 1 and `txdStrongPull` to 0 in standby), before the enable qualification completes.
- R10: In sleep, the edge that completes `NORM_DELAY` consecutive high samples of `enPin` enters run directly. This qualified enable takes priority over a wake pulse on the same edge.
- R11: Wake pulses in off, standby or run set no flag and change no mode.
- R12: In standby a low `enPin` has no effect: the block stays in standby, whatever the length of the low level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyOk | input | 1 | Supply valid, hysteresis already applied |
| enPin | input | 1 | Host enable pin, synchronised |
| busWake | input | 1 | Qualified remote wake pulse from the bus filter |
| localWake | input | 1 | Qualified local wake pulse from the switch filter |
| busRx | input | 1 | Receiver comparator level (1 = recessive) |
| inhibit | output | 1 | Regulator enable (high-side switch on) |
| commEnable | output | 1 | Transmit and receive paths active |
| termEnable | output | 1 | Bus termination resistor connected |
| rxdOut | output | 1 | Receive output level; 0 in standby signals a wake request |
| txdStrongPull | output | 1 | Strong pull-down on the transmit pin, marking a local wake |

## Verification
The bench goes after enable pulses one sample short of each qualification delay, which a design with an off-by-one counter would accept as a mode change. It drives a wake together with a qualified enable in sleep, where a wrong priority would stop in standby instead of run. It also drives wake pulses in both wake inputs at once, and wakes in run or standby, which a careless flag path would latch as a stale wake request. It checks that the flags drop on the first enable sample rather than at the mode change, and that a supply loss mid-run clears everything.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_STBY  = 2'd1,
    MODE_RUN   = 2'd2,
    MODE_SLEEP = 2'd3
  } modeT;

  // Strobes from the mode sequencer to the datapath
  typedef struct packed {
    modeT modeNext;
    logic setWake;
    logic wakeLocal;
    logic clearFlags;
  } ctrlStrobeT;

endpackage

// File: rtl/lin_level_qual.sv
// Counts consecutive samples of one level; qualified once HOLD samples are seen.
module lin_level_qual #(
  parameter int HOLD  = 10,
  parameter bit LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic sigIn,
  output logic qualified
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] runCnt;
  logic          atLevel;

  assign atLevel   = (sigIn == LEVEL);
  assign qualified = atLevel && (runCnt >= LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (!atLevel) begin
      runCnt <= '0;
    end else if (runCnt != LAST) begin
      runCnt <= runCnt + 1'b1;
    end
  end
endmodule

// File: rtl/lin_mode_fsm.sv
module lin_mode_fsm
  import lin_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic       enPin,
  input  logic       busWake,
  input  logic       localWake,
  input  logic       enHighQual,
  input  logic       enLowQual,
  output ctrlStrobeT strobes
);
  modeT mode;
  modeT modeNext;
  logic anyWake;

  assign anyWake = busWake || localWake;

  always_comb begin
    modeNext = mode;
    unique case (mode)
      MODE_OFF:   if (supplyOk) modeNext = MODE_STBY;
      MODE_STBY:  if (enHighQual) modeNext = MODE_RUN;
      MODE_RUN:   if (enLowQual) modeNext = MODE_SLEEP;
      MODE_SLEEP: begin
        if (enHighQual)   modeNext = MODE_RUN;
        else if (anyWake) modeNext = MODE_STBY;
      end
      default:    modeNext = MODE_OFF;
    endcase
    if (!supplyOk) modeNext = MODE_OFF;
  end

  always_comb begin
    strobes.modeNext   = modeNext;
    strobes.setWake    = supplyOk && (mode == MODE_SLEEP) && !enHighQual && anyWake;
    strobes.wakeLocal  = localWake;
    strobes.clearFlags = enPin || !supplyOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mode <= MODE_OFF;
    else       mode <= modeNext;
  end
endmodule

// File: rtl/lin_mode_dp.sv
module lin_mode_dp
  import lin_mode_pkg::*;
#(
  parameter int NORM_DELAY  = 10,
  parameter int SLEEP_DELAY = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enPin,
  input  logic       busRx,
  input  ctrlStrobeT strobes,
  output logic       enHighQual,
  output logic       enLowQual,
  output logic       inhibit,
  output logic       commEnable,
  output logic       termEnable,
  output logic       rxdOut,
  output logic       txdStrongPull
);
  localparam int NUM_QUAL = 2;

  logic [NUM_QUAL-1:0] qualVec;

  // index 0 qualifies the low level (sleep entry), index 1 the high level
  for (genvar q = 0; q < NUM_QUAL; q++) begin : gQual
    lin_level_qual #(
      .HOLD (q == 1 ? NORM_DELAY : SLEEP_DELAY),
      .LEVEL(q == 1)
    ) uQual (
      .clk      (clk),
      .rstN     (rstN),
      .sigIn    (enPin),
      .qualified(qualVec[q])
    );
  end

  assign enLowQual  = qualVec[0];
  assign enHighQual = qualVec[1];

  logic wakeReq;
  logic wakeSrc;
  logic wakeReqNext;
  logic wakeSrcNext;
  logic isStby;
  logic isRun;

  always_comb begin
    wakeReqNext = wakeReq;
    wakeSrcNext = wakeSrc;
    if (strobes.clearFlags) begin
      wakeReqNext = 1'b0;
      wakeSrcNext = 1'b0;
    end else if (strobes.setWake) begin
      wakeReqNext = 1'b1;
      wakeSrcNext = strobes.wakeLocal;
    end
  end

  assign isStby = (strobes.modeNext == MODE_STBY);
  assign isRun  = (strobes.modeNext == MODE_RUN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeReq       <= 1'b0;
      wakeSrc       <= 1'b0;
      inhibit       <= 1'b0;
      commEnable    <= 1'b0;
      termEnable    <= 1'b0;
      rxdOut        <= 1'b1;
      txdStrongPull <= 1'b0;
    end else begin
      wakeReq       <= wakeReqNext;
      wakeSrc       <= wakeSrcNext;
      inhibit       <= isStby || isRun;
      commEnable    <= isRun;
      termEnable    <= isStby || isRun;
      rxdOut        <= isRun ? busRx : (isStby ? !wakeReqNext : 1'b1);
      txdStrongPull <= isStby && wakeReqNext && wakeSrcNext;
    end
  end
endmodule

// File: rtl/lin_mode_controller.sv
module lin_mode_controller
  import lin_mode_pkg::*;
#(
  parameter int NORM_DELAY  = 10,
  parameter int SLEEP_DELAY = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyOk,
  input  logic enPin,
  input  logic busWake,
  input  logic localWake,
  input  logic busRx,
  output logic inhibit,
  output logic commEnable,
  output logic termEnable,
  output logic rxdOut,
  output logic txdStrongPull
);
  ctrlStrobeT strobes;
  logic       enHighQual;
  logic       enLowQual;

  lin_mode_fsm uFsm (
    .clk       (clk),
    .rstN      (rstN),
    .supplyOk  (supplyOk),
    .enPin     (enPin),
    .busWake   (busWake),
    .localWake (localWake),
    .enHighQual(enHighQual),
    .enLowQual (enLowQual),
    .strobes   (strobes)
  );

  lin_mode_dp #(
    .NORM_DELAY (NORM_DELAY),
    .SLEEP_DELAY(SLEEP_DELAY)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .enPin        (enPin),
    .busRx        (busRx),
    .strobes      (strobes),
    .enHighQual   (enHighQual),
    .enLowQual    (enLowQual),
    .inhibit      (inhibit),
    .commEnable   (commEnable),
    .termEnable   (termEnable),
    .rxdOut       (rxdOut),
    .txdStrongPull(txdStrongPull)
  );
endmodule

// File: rtl/lin_mode_checker.sv
module lin_mode_checker (
  input logic clk,
  input logic rstN,
  input logic supplyOk,
  input logic enPin,
  input logic busWake,
  input logic localWake,
  input logic inhibit,
  input logic commEnable,
  input logic termEnable,
  input logic rxdOut,
  input logic txdStrongPull
);
  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R3: supply loss powers everything down at the next edge
  a_r3_supply_loss: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> (!inhibit && !commEnable && !termEnable && !txdStrongPull));

  // R2: fresh supply enables the regulator one edge later
  a_r2_powerup_inhibit: assert property (@(posedge clk) disable iff (!rstN)
    (armed && supplyOk && !$past(supplyOk)) |=> inhibit);

  // R4: communication only with regulator and termination on
  a_r4_run_outputs: assert property (@(posedge clk) disable iff (!rstN)
    commEnable |-> (inhibit && termEnable));

  // R9: enable sampled high drops the wake source indication
  a_r9_enable_clears: assert property (@(posedge clk) disable iff (!rstN)
    enPin |=> !txdStrongPull);

  // R8: source indication only together with the wake request in standby
  a_r8_source_with_request: assert property (@(posedge clk) disable iff (!rstN)
    txdStrongPull |-> (!rxdOut && inhibit && !commEnable));

  // R11: a wake seen in run cannot raise the source indication
  a_r11_wake_in_run: assert property (@(posedge clk) disable iff (!rstN)
    (commEnable && (busWake || localWake)) |=> !txdStrongPull);
endmodule

bind lin_mode_controller lin_mode_checker uChk (
  .clk          (clk),
  .rstN         (rstN),
  .supplyOk     (supplyOk),
  .enPin        (enPin),
  .busWake      (busWake),
  .localWake    (localWake),
  .inhibit      (inhibit),
  .commEnable   (commEnable),
  .termEnable   (termEnable),
  .rxdOut       (rxdOut),
  .txdStrongPull(txdStrongPull)
);

// File: tb/lin_mode_controller_test.sv
module lin_mode_controller_test;
  localparam int CLK_PERIOD = 10;
  localparam int NORM  = 6;
  localparam int SLP   = 4;
  localparam int LIMIT = 200000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyOk = 1'b0, enPin = 1'b0, busWake = 1'b0, localWake = 1'b0, busRx = 1'b1;
  logic inhibit, commEnable, termEnable, rxdOut, txdStrongPull;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // reference state: 0 off, 1 standby, 2 run, 3 sleep
  int mMode = 0, mHi = 0, mLo = 0;
  bit mReq = 0, mSrc = 0;
  bit eInh = 0, eComm = 0, eTerm = 0, eRxd = 1, eTxd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_mode_controller #(.NORM_DELAY(NORM), .SLEEP_DELAY(SLP)) uut (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .enPin(enPin),
    .busWake(busWake), .localWake(localWake), .busRx(busRx),
    .inhibit(inhibit), .commEnable(commEnable), .termEnable(termEnable),
    .rxdOut(rxdOut), .txdStrongPull(txdStrongPull));

  function automatic string modeTag(int m);
    case (m)
      0: return "R3";
      1: return "R12";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic modelStep();
    bit qH, qL, wk;
    int nMode;
    mHi = enPin ? ((mHi < 1000) ? mHi + 1 : mHi) : 0;
    mLo = !enPin ? ((mLo < 1000) ? mLo + 1 : mLo) : 0;
    qH = enPin && (mHi >= NORM);
    qL = !enPin && (mLo >= SLP);
    wk = busWake || localWake;
    nMode = mMode;
    if (!supplyOk) nMode = 0;
    else if (mMode == 0) nMode = 1;
    else if (mMode == 1 && qH) nMode = 2;
    else if (mMode == 2 && qL) nMode = 3;
    else if (mMode == 3 && qH) nMode = 2;
    else if (mMode == 3 && wk) nMode = 1;
    if (enPin || !supplyOk) begin
      mReq = 0; mSrc = 0;
    end else if (mMode == 3 && wk && !qH) begin
      mReq = 1; mSrc = localWake;
    end
    mMode = nMode;
    eInh  = (mMode == 1 || mMode == 2);
    eTerm = eInh;
    eComm = (mMode == 2);
    eRxd  = (mMode == 2) ? busRx : ((mMode == 1) ? !mReq : 1'b1);
    eTxd  = (mMode == 1) && mReq && mSrc;
  endtask

  task automatic compare(string tag);
    compared++;
    if ({inhibit, commEnable, termEnable, rxdOut, txdStrongPull} !==
        {eInh, eComm, eTerm, eRxd, eTxd}) begin
      mismatched++;
      $display("FAIL %s: inh/comm/term/rxd/txd actual %b%b%b%b%b expected %b%b%b%b%b at %0t",
               tag, inhibit, commEnable, termEnable, rxdOut, txdStrongPull,
               eInh, eComm, eTerm, eRxd, eTxd, $time);
    end
  endtask

  // inputs already set (at a falling edge); step one edge and compare
  task automatic step(string tag);
    modelStep();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic steps(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    int runLeft;
    void'($urandom(32'h1F3A));
    @(negedge clk);
    @(negedge clk);
    compare("R1");
    rstN = 1'b1;

    supplyOk = 1'b1;
    step("R2");
    steps(8, "R12");                    // standby, enable low
    enPin = 1'b1; steps(NORM - 1, "R6"); // one short
    enPin = 1'b0; step("R6");
    enPin = 1'b1; steps(NORM, "R4");
    for (int i = 0; i < 6; i++) begin busRx = i[0]; step("R4"); end
    localWake = 1'b1; busWake = 1'b1; step("R11");
    localWake = 1'b0; busWake = 1'b0;
    enPin = 1'b0; steps(SLP - 1, "R6");
    enPin = 1'b1; step("R6");
    enPin = 1'b0; steps(SLP, "R5");
    steps(3, "R5");
    busWake = 1'b1; step("R7");
    busWake = 1'b0; steps(3, "R7");
    localWake = 1'b1; step("R11");       // wake in standby ignored
    localWake = 1'b0;
    enPin = 1'b1; step("R9");
    steps(NORM - 1, "R4");
    enPin = 1'b0; steps(SLP, "R5");
    localWake = 1'b1; step("R8");
    localWake = 1'b0; steps(2, "R8");
    enPin = 1'b1; steps(NORM, "R4");
    enPin = 1'b0; steps(SLP, "R5");
    busWake = 1'b1; localWake = 1'b1; step("R8");
    busWake = 1'b0; localWake = 1'b0; steps(2, "R8");
    enPin = 1'b1; steps(NORM, "R9");
    enPin = 1'b0; steps(SLP + 2, "R5");
    enPin = 1'b1; steps(NORM - 1, "R10");
    busWake = 1'b1; step("R10");         // qualified enable beats wake
    busWake = 1'b0; steps(2, "R10");
    supplyOk = 1'b0; step("R3");
    supplyOk = 1'b1; step("R2");
    enPin = 1'b0; supplyOk = 1'b0; steps(2, "R3");

    runLeft = 0;
    for (int c = 0; c < 6000; c++) begin
      supplyOk  = ($urandom % 300) != 0;
      if (runLeft == 0) begin
        enPin   = $urandom % 2;
        runLeft = 1 + ($urandom % 9);
      end
      runLeft--;
      busWake   = ($urandom % 20) == 0;
      localWake = ($urandom % 25) == 0;
      busRx     = $urandom % 2;
      step(modeTag(mMode));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule